// File: doc/BRIEF.md
# Programmed Serial Line Controller

This block is an asynchronous character line controller that a small processor drives through strobed commands, byte write ports and sense outputs. It sends and receives ten-bit characters on a single wire. Each character is a space start bit, eight data bits with the least significant bit first, and a mark stop bit. Parity, line break, mark fill and start-bit tracking are not fixed behaviour. Each one is a separate command or sense line, so the controlling program decides how the line is run.

The processor loads a transmit byte into a one-byte buffer and then issues a transfer command. It loads a 15-bit byte counter in two halves and reads the received byte. It watches a six-bit status word whose OR is the service-request sense. An interrupt output follows that service request, but only while interrupts are enabled. Break and fill commands take effect only while the transmitter is idle with an empty buffer.

Top module: `sline_ctrl`

## Requirements
- R1: An initialise command (cmd_op 0) resets the controller. On the next cycle the line is at mark, all status bits are 0 and irq is 0. Interrupts stay disabled until they are enabled again, and any frame in progress is abandoned.
- R2: irq is 1 exactly when interrupts are enabled and sense_svc is 1. Enable is cmd_op 1 and disable is cmd_op 2, and after a disable irq reads 0.
- R3: sense_txpar is the XOR of the seven accumulator bits acc[6:0].
- R4: A transfer command (cmd_op 3) sends the buffered byte, starting one clock after the command edge. The frame is a space start bit, data bits 0 to 7, then a mark stop bit, each held for CLKS_PER_BIT clocks. A byte loaded while a frame is in flight follows the current stop bit with no gap. sense_line reports the transmit line.
- R5: status[0] (transmitter needs data) sets when a byte moves from the buffer into the shifter, and a data-byte write (bo_sel 0) clears it. status[4] (transmit complete) sets when a stop bit or break ends with an empty buffer, and a transfer command clears it.
- R6: A write with bo_sel 1 loads byte_count[14:8] from bo_data[6:0], and bo_sel 2 loads byte_count[7:0]. Each byte moved into the shifter decrements the count. A move that finds the count at 0 wraps it to 0x7FFF and sets status[3].
- R7: A break command (cmd_op 4) drives the line to space from the command edge for 10*CLKS_PER_BIT clocks. The line then returns to mark and status[4] sets.
- R8: A fill-on command (cmd_op 5) holds the line at mark. Until a fill-off command (cmd_op 6), status[0] sets every FILL_CLKS clocks, first at FILL_CLKS clocks after the command edge.
- R9: The receiver samples each bit at its middle. A good frame updates rx_data and sets status[1]. sense_rxpar is 1 when the parity of the received bits 0 to 6 differs from received bit 7.
- R10: sense_start is 1 from detection of a start bit until the stop bit, the tenth bit, is sampled.
- R11: A frame with all data bits and the stop bit at space sets status[2] and does not set status[1]. A good frame that completes while status[1] is still set also sets status[5] (overrun).
- R12: rd_ack clears status[1], status[2] and status[5].
- R13: sense_svc is the OR of status[5:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code: 0 init, 1 irq enable, 2 irq disable, 3 transfer, 4 break, 5 fill on, 6 fill off |
| bo_valid | input | 1 | Byte write strobe |
| bo_sel | input | 2 | Byte write target: 0 transmit buffer, 1 counter high, 2 counter low |
| bo_data | input | 8 | Byte write data |
| rd_ack | input | 1 | Receive status acknowledge |
| acc | input | 7 | Accumulator bits for the parity sense |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Interrupt request |
| sense_svc | output | 1 | Service request |
| sense_txpar | output | 1 | Parity of acc |
| sense_line | output | 1 | Transmit line state |
| sense_rxpar | output | 1 | Receive parity mismatch |
| sense_start | output | 1 | Receive frame in progress |
| status | output | 6 | need, rx done, break rx, count overflow, tx done, overrun (bits 0..5) |
| rx_data | output | 8 | Last good received byte |
| byte_count | output | 15 | Byte counter |

## Verification
The bench writes its second byte while the first frame is still on the wire. A buffer handoff that took one cycle too many would then put an extra mark between the frames, and the per-cycle line comparison catches it. It runs the counter through zero, where a design that saturates, or that forgets the overflow flag, gives the wrong count. It aborts a frame with initialise, which shows any bit left driving the line or an enable left set. It also counts fill ticks to the exact clock, and sends an all-space frame with a bad stop bit, which a careless receiver reports as a received byte.

// File: rtl/sline_pkg.sv
package sline_pkg;
  typedef enum logic [2:0] {
    OP_INIT     = 3'd0,
    OP_IEN      = 3'd1,
    OP_IDIS     = 3'd2,
    OP_XFER     = 3'd3,
    OP_BREAK    = 3'd4,
    OP_FILL_ON  = 3'd5,
    OP_FILL_OFF = 3'd6,
    OP_NOP      = 3'd7
  } cmd_op_e;

  localparam int ST_W      = 6;
  localparam int ST_NEED   = 0;
  localparam int ST_RXDONE = 1;
  localparam int ST_BRKRX  = 2;
  localparam int ST_OVF    = 3;
  localparam int ST_TXDONE = 4;
  localparam int ST_OVR    = 5;

  function automatic logic par7(input logic [6:0] b);
    return ^b;
  endfunction

  function automatic logic par_err(input logic [7:0] b);
    return (^b[6:0]) != b[7];
  endfunction

  function automatic logic [9:0] make_frame(input logic [7:0] b);
    return {1'b1, b, 1'b0};
  endfunction
endpackage

// File: rtl/sline_tx.sv
module sline_tx
  import sline_pkg::*;
#(
  parameter int CPB = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init,
  input  logic       brk_req,
  input  logic       fill_on,
  input  logic       hold_full,
  input  logic [7:0] hold_data,
  output logic       take,
  output logic       done,
  output logic       txd,
  output logic       busy
);
  localparam int CW = (CPB > 2) ? $clog2(CPB) : 1;

  typedef enum logic [1:0] {T_IDLE, T_DATA, T_BRK} tst_e;

  tst_e          st;
  logic [9:0]    sh;
  logic [3:0]    bitn;
  logic [CW-1:0] cnt;
  logic          bit_end, last_bit;

  assign bit_end  = (st != T_IDLE) && (cnt == CW'(CPB - 1));
  assign last_bit = bit_end && (bitn == 4'd9);
  assign take     = hold_full && !fill_on && !init &&
                    ((st == T_IDLE) || (st == T_DATA && last_bit));
  assign done     = last_bit && !take;
  assign busy     = (st != T_IDLE);
  assign txd      = (st == T_DATA) ? sh[0] : (st != T_BRK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= T_IDLE; sh <= '1; bitn <= 4'hF; cnt <= '0;
    end else if (init) begin
      st <= T_IDLE; sh <= '1; bitn <= 4'hF; cnt <= '0;
    end else if (take) begin
      st <= T_DATA; sh <= make_frame(hold_data); bitn <= 4'd0; cnt <= '0;
    end else if (st == T_IDLE) begin
      if (brk_req && !hold_full) begin
        st <= T_BRK; bitn <= 4'd0; cnt <= '0;
      end
    end else if (bit_end) begin
      cnt <= '0;
      sh  <= {1'b1, sh[9:1]};
      if (bitn == 4'd9) begin
        st <= T_IDLE; bitn <= 4'hF;
      end else begin
        bitn <= bitn + 4'd1;
      end
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  // R4: every frame opens with a space start bit
  a_r4_start_space: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !txd);
  // R4: the final clock of a data frame is at mark
  a_r4_stop_mark: assert property (@(posedge clk) disable iff (!rst_n)
    (last_bit && st == T_DATA) |-> txd);
endmodule

// File: rtl/sline_rx.sv
module sline_rx
  import sline_pkg::*;
#(
  parameter int CPB = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init,
  input  logic       rxd,
  output logic [7:0] data,
  output logic       done,
  output logic       brk,
  output logic       start,
  output logic       perr
);
  localparam int CW   = (CPB > 2) ? $clog2(CPB) : 1;
  localparam int HALF = CPB / 2;

  typedef enum logic [1:0] {R_IDLE, R_RUN, R_WAIT} rst_e;

  rst_e          st;
  logic          s1, s2;
  logic [7:0]    shreg;
  logic [3:0]    bitn;
  logic [CW-1:0] cnt;
  logic          samp, stop_samp, brk_c;

  assign samp      = (st == R_RUN) &&
                     (cnt == ((bitn == 4'd0) ? CW'(HALF - 1) : CW'(CPB - 1)));
  assign stop_samp = samp && (bitn == 4'd9);
  assign brk_c     = (shreg == 8'h00) && !s2;
  assign brk       = stop_samp && brk_c;
  assign done      = stop_samp && !brk_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1;
    end else begin
      s1 <= rxd; s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= R_IDLE; bitn <= 4'hF; cnt <= '0; start <= 1'b0;
      shreg <= '0; data <= '0; perr <= 1'b0;
    end else if (init) begin
      st <= R_IDLE; bitn <= 4'hF; cnt <= '0; start <= 1'b0;
      shreg <= '0; data <= '0; perr <= 1'b0;
    end else begin
      unique case (st)
        R_IDLE: if (!s2) begin
          st <= R_RUN; cnt <= '0; bitn <= 4'd0; start <= 1'b1;
        end
        R_RUN: if (samp) begin
          cnt <= '0;
          if (bitn == 4'd0) begin
            if (s2) begin st <= R_IDLE; start <= 1'b0; bitn <= 4'hF; end
            else bitn <= 4'd1;
          end else if (bitn == 4'd9) begin
            start <= 1'b0; bitn <= 4'hF;
            if (brk_c) st <= R_WAIT;
            else begin
              st <= R_IDLE; data <= shreg; perr <= par_err(shreg);
            end
          end else begin
            shreg <= {s2, shreg[7:1]};
            bitn  <= bitn + 4'd1;
          end
        end else begin
          cnt <= cnt + CW'(1);
        end
        R_WAIT: if (s2) st <= R_IDLE;
        default: st <= R_IDLE;
      endcase
    end
  end

  // R10: start sense is held for the whole frame
  a_r10_start_held: assert property (@(posedge clk) disable iff (!rst_n)
    (st == R_RUN) |-> start);
  // R10: start sense drops once the stop bit is sampled
  a_r10_start_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (done || brk) |=> !start);
endmodule

// File: rtl/sline_ctrl.sv
module sline_ctrl
  import sline_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter int FILL_CLKS    = 1600,
  parameter int CNT_W        = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic             bo_valid,
  input  logic [1:0]       bo_sel,
  input  logic [7:0]       bo_data,
  input  logic             rd_ack,
  input  logic [6:0]       acc,
  input  logic             rxd,
  output logic             txd,
  output logic             irq,
  output logic             sense_svc,
  output logic             sense_txpar,
  output logic             sense_line,
  output logic             sense_rxpar,
  output logic             sense_start,
  output logic [ST_W-1:0]  status,
  output logic [7:0]       rx_data,
  output logic [CNT_W-1:0] byte_count
);
  localparam int HI_W = CNT_W - 8;
  localparam int FW   = (FILL_CLKS > 2) ? $clog2(FILL_CLKS) : 1;

  logic is_init, is_ien, is_idis, is_xfer, is_brk, is_fon, is_foff;
  logic wr_dat, wr_hi, wr_lo;
  logic irq_en, hold_full, fill_on, fill_tick;
  logic [7:0] hold_data;
  logic [FW-1:0] fill_cnt;
  logic take, tx_done_p, tx_busy, rx_done_p, rx_brk_p;
  logic [ST_W-1:0] st_set, st_clr;

  assign is_init = cmd_valid && cmd_op == OP_INIT;
  assign is_ien  = cmd_valid && cmd_op == OP_IEN;
  assign is_idis = cmd_valid && cmd_op == OP_IDIS;
  assign is_xfer = cmd_valid && cmd_op == OP_XFER;
  assign is_brk  = cmd_valid && cmd_op == OP_BREAK;
  assign is_fon  = cmd_valid && cmd_op == OP_FILL_ON;
  assign is_foff = cmd_valid && cmd_op == OP_FILL_OFF;
  assign wr_dat  = bo_valid && bo_sel == 2'd0;
  assign wr_hi   = bo_valid && bo_sel == 2'd1;
  assign wr_lo   = bo_valid && bo_sel == 2'd2;

  sline_tx #(.CPB(CLKS_PER_BIT)) u_tx (
    .clk(clk), .rst_n(rst_n), .init(is_init), .brk_req(is_brk),
    .fill_on(fill_on), .hold_full(hold_full), .hold_data(hold_data),
    .take(take), .done(tx_done_p), .txd(txd), .busy(tx_busy)
  );

  sline_rx #(.CPB(CLKS_PER_BIT)) u_rx (
    .clk(clk), .rst_n(rst_n), .init(is_init), .rxd(rxd),
    .data(rx_data), .done(rx_done_p), .brk(rx_brk_p),
    .start(sense_start), .perr(sense_rxpar)
  );

  assign fill_tick = fill_on && (fill_cnt == FW'(FILL_CLKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en <= 1'b0; hold_full <= 1'b0; hold_data <= '0;
      fill_on <= 1'b0; fill_cnt <= '0;
    end else if (is_init) begin
      irq_en <= 1'b0; hold_full <= 1'b0;
      fill_on <= 1'b0; fill_cnt <= '0;
    end else begin
      if (is_ien) irq_en <= 1'b1;
      else if (is_idis) irq_en <= 1'b0;
      if (wr_dat) hold_data <= bo_data;
      if (is_xfer) hold_full <= 1'b1;
      else if (take) hold_full <= 1'b0;
      if (is_fon) begin
        fill_on <= 1'b1; fill_cnt <= '0;
      end else if (is_foff) begin
        fill_on <= 1'b0; fill_cnt <= '0;
      end else if (fill_on) begin
        fill_cnt <= fill_tick ? '0 : fill_cnt + FW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) byte_count <= '0;
    else if (wr_hi || wr_lo) begin
      if (wr_hi) byte_count[CNT_W-1:8] <= bo_data[HI_W-1:0];
      if (wr_lo) byte_count[7:0] <= bo_data;
    end else if (take) byte_count <= byte_count - CNT_W'(1);
  end

  always_comb begin
    st_set = '0;
    st_clr = '0;
    st_set[ST_NEED]   = take || fill_tick;
    st_clr[ST_NEED]   = wr_dat;
    st_set[ST_RXDONE] = rx_done_p;
    st_clr[ST_RXDONE] = rd_ack;
    st_set[ST_BRKRX]  = rx_brk_p;
    st_clr[ST_BRKRX]  = rd_ack;
    st_set[ST_OVF]    = take && (byte_count == '0) && !wr_hi && !wr_lo;
    st_clr[ST_OVF]    = wr_hi || wr_lo;
    st_set[ST_TXDONE] = tx_done_p;
    st_clr[ST_TXDONE] = is_xfer;
    st_set[ST_OVR]    = rx_done_p && status[ST_RXDONE];
    st_clr[ST_OVR]    = rd_ack;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else if (is_init) status <= '0;
    else status <= (status & ~st_clr) | st_set;
  end

  assign sense_svc   = |status;
  assign irq         = irq_en && sense_svc;
  assign sense_txpar = par7(acc);
  assign sense_line  = txd;

  // R1: initialise leaves a quiet, marking controller
  a_r1_init_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    is_init |=> (status == '0 && !irq && txd));
  // R2: a disable command silences the interrupt
  a_r2_disable: assert property (@(posedge clk) disable iff (!rst_n)
    is_idis |=> !irq);
  // R5: the buffer handoff raises transmitter-needs-data
  a_r5_need: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> status[ST_NEED]);
  // R6: high counter port lands in bits 14..8
  a_r6_hi_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> byte_count[CNT_W-1:8] == $past(bo_data[HI_W-1:0]));
  // R6: decrement through zero wraps and flags
  a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (take && byte_count == '0 && !wr_hi && !wr_lo) |=> (byte_count == '1 && status[ST_OVF]));
  // R8: fill keeps an idle line at mark
  a_r8_fill_mark: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_on && !tx_busy) |-> txd);
endmodule

// File: tb/sline_ctrl_bench.sv
module sline_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CPB  = 8;
  localparam int FILL = 50;
  localparam logic [2:0] C_INIT = 3'd0, C_IEN = 3'd1, C_IDIS = 3'd2, C_XFER = 3'd3,
                         C_BREAK = 3'd4, C_FON = 3'd5, C_FOFF = 3'd6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, bo_valid = 1'b0, rd_ack = 1'b0, rxd = 1'b1;
  logic [2:0] cmd_op = 3'd7;
  logic [1:0] bo_sel = 2'd0;
  logic [7:0] bo_data = 8'd0;
  logic [6:0] acc = 7'd0;
  logic txd, irq, sense_svc, sense_txpar, sense_line, sense_rxpar, sense_start;
  logic [5:0] status;
  logic [7:0] rx_data;
  logic [14:0] byte_count;

  int n_tests = 0, n_fail = 0;
  bit run_cmp = 1'b0;
  bit q[$];
  logic [7:0] m_hold = 8'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sline_ctrl #(.CLKS_PER_BIT(CPB), .FILL_CLKS(FILL), .CNT_W(15)) u_sline_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .bo_valid(bo_valid), .bo_sel(bo_sel), .bo_data(bo_data), .rd_ack(rd_ack),
    .acc(acc), .rxd(rxd), .txd(txd), .irq(irq), .sense_svc(sense_svc),
    .sense_txpar(sense_txpar), .sense_line(sense_line), .sense_rxpar(sense_rxpar),
    .sense_start(sense_start), .status(status), .rx_data(rx_data),
    .byte_count(byte_count)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // R4: per-cycle line model built from queued bit levels
  always @(posedge clk) begin
    #1;
    if (run_cmp) begin
      bit e;
      e = (q.size() != 0) ? q.pop_front() : 1'b1;
      chk("R4 line level", txd, e);
      chk("R4 sense_line", sense_line, e);
    end
  end

  task automatic push_frame(input logic [7:0] b);
    for (int k = 0; k < 10; k++) begin
      bit lv;
      lv = (k == 0) ? 1'b0 : (k == 9) ? 1'b1 : b[k-1];
      for (int c = 0; c < CPB; c++) q.push_back(lv);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  task automatic cmd(input logic [2:0] op);
    @(posedge clk); #3;
    cmd_valid = 1'b1; cmd_op = op;
    if (op == C_XFER) begin
      if (q.size() == 0) q.push_back(1'b1);
      push_frame(m_hold);
    end else if (op == C_BREAK) begin
      for (int i = 0; i < 10*CPB; i++) q.push_back(1'b0);
    end else if (op == C_INIT) begin
      q.delete();
    end
    @(posedge clk); #3;
    cmd_valid = 1'b0; cmd_op = 3'd7;
  endtask

  task automatic bo(input logic [1:0] sel, input logic [7:0] d);
    @(posedge clk); #3;
    bo_valid = 1'b1; bo_sel = sel; bo_data = d;
    if (sel == 2'd0) m_hold = d;
    @(posedge clk); #3;
    bo_valid = 1'b0;
  endtask

  task automatic ack();
    @(posedge clk); #3; rd_ack = 1'b1;
    @(posedge clk); #3; rd_ack = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(posedge clk);
    wait_cyc(2);
  endtask

  task automatic send_rx(input logic [7:0] b, input logic stopb);
    for (int k = 0; k < 10; k++) begin
      @(posedge clk); #3;
      rxd = (k == 0) ? 1'b0 : (k == 9) ? stopb : b[k-1];
      if (k == 4) chk("R10 start sense mid-frame", sense_start, 1'b1);
      repeat (CPB-1) @(posedge clk);
    end
  endtask

  function automatic logic ref_par(input logic [6:0] v);
    int ones = 0;
    for (int i = 0; i < 7; i++) if (v[i]) ones++;
    return logic'(ones % 2);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hung expected finish");
    report();
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    run_cmp = 1'b1;
    wait_cyc(1);
    // R1: reset state
    chk("R1 reset txd", txd, 1'b1);
    chk("R1 reset irq", irq, 1'b0);
    chk("R1 reset status", status, 6'd0);
    chk("R10 reset start sense", sense_start, 1'b0);

    // R3: transmit parity sense
    begin
      logic [6:0] pats [5] = '{7'h00, 7'h7F, 7'h55, 7'h01, 7'h2C};
      foreach (pats[i]) begin
        acc = pats[i];
        #1;
        chk("R3 txpar", sense_txpar, ref_par(pats[i]));
      end
    end

    // R6: counter halves
    bo(2'd1, 8'h85);
    bo(2'd2, 8'h02);
    chk("R6 count load", byte_count, 15'h0502);
    bo(2'd1, 8'h00);
    chk("R6 count hi reload", byte_count, 15'h0002);

    // R2, R4, R5: back-to-back frames
    cmd(C_IEN);
    chk("R2 irq quiet without service", irq, 1'b0);
    bo(2'd0, 8'hA5);
    cmd(C_XFER);
    wait_cyc(3);
    chk("R5 need after handoff", status[0], 1'b1);
    chk("R2 irq follows service", irq, 1'b1);
    chk("R6 count dec", byte_count, 15'h0001);
    bo(2'd0, 8'h3C);
    chk("R5 need cleared by write", status[0], 1'b0);
    cmd(C_XFER);
    drain();
    chk("R6 count at zero", byte_count, 15'h0000);
    chk("R5 tx done", status[4], 1'b1);
    chk("R13 svc", sense_svc, 1'b1);
    bo(2'd0, 8'hFF);
    cmd(C_XFER);
    chk("R5 tx done cleared by transfer", status[4], 1'b0);
    wait_cyc(2);
    chk("R6 wrap", byte_count, 15'h7FFF);
    chk("R6 overflow flag", status[3], 1'b1);
    drain();
    chk("R2 irq before disable", irq, 1'b1);
    cmd(C_IDIS);
    chk("R2 irq after disable", irq, 1'b0);

    // R1: init aborts a frame
    cmd(C_IEN);
    bo(2'd0, 8'h81);
    cmd(C_XFER);
    wait_cyc(3*CPB);
    cmd(C_INIT);
    chk("R1 init status", status, 6'd0);
    chk("R1 init irq", irq, 1'b0);
    chk("R1 init txd", txd, 1'b1);

    // R7: break
    cmd(C_BREAK);
    wait_cyc(5*CPB);
    chk("R7 break space", txd, 1'b0);
    drain();
    chk("R7 break complete", status[4], 1'b1);

    // R8: fill ticks
    cmd(C_FON);
    bo(2'd0, 8'h00);
    wait_cyc(FILL-3);
    chk("R8 before tick", status[0], 1'b0);
    wait_cyc(1);
    chk("R8 tick", status[0], 1'b1);
    chk("R8 line mark", txd, 1'b1);
    cmd(C_FOFF);

    // R9..R13: receiver
    cmd(C_INIT);
    send_rx(8'h5A, 1'b1);
    wait_cyc(CPB);
    chk("R10 start sense after stop", sense_start, 1'b0);
    chk("R9 rx data", rx_data, 8'h5A);
    chk("R9 rxpar good", sense_rxpar, 1'b0);
    chk("R9 rx status", status, 6'b000010);
    chk("R13 svc from rx", sense_svc, 1'b1);
    chk("R1 enable cleared by init", irq, 1'b0);
    send_rx(8'hC1, 1'b1);
    wait_cyc(CPB);
    chk("R9 rx data 2", rx_data, 8'hC1);
    chk("R9 rxpar bad", sense_rxpar, (ref_par(7'h41) != 1'b1) ? 1'b1 : 1'b0);
    chk("R11 overrun", status[5], 1'b1);
    ack();
    chk("R12 ack clears", status, 6'd0);
    chk("R13 svc clear", sense_svc, 1'b0);

    send_rx(8'h00, 1'b0);
    wait_cyc(2*CPB);
    @(posedge clk); #3; rxd = 1'b1;
    wait_cyc(2*CPB);
    chk("R11 break received", status[2], 1'b1);
    chk("R11 break not a byte", status[1], 1'b0);
    chk("R11 data kept", rx_data, 8'hC1);
    ack();
    chk("R12 ack clears break", status[2], 1'b0);

    wait_cyc(4);
    report();
  end
endmodule